// File: doc/BRIEF.md
# Coefficient Size-Category and Amplitude Encoder

This block prepares quantized transform coefficients for baseline entropy coding. For each signed coefficient it produces a size category, which is the number of bits needed to hold the magnitude, and the amplitude bits that a downstream coder appends after the variable-length code. Positive values pass their magnitude through unchanged. Negative values are sent as the inverted magnitude, cut down to the category width. The result equals the value minus one, kept to that many bits.

A coefficient flagged as the block's DC term is not coded directly. Its difference from the previous DC term of the same colour component is coded instead, and that component's predictor then takes the new value. The predictors clear on reset and on a scan-restart pulse. Coefficients enter on a valid/ready handshake and leave one cycle later on a second valid/ready handshake. When the output side accepts, the block takes one coefficient per cycle.

Top module: `coef_category_encoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and every component's DC predictor is zero. The first DC term of each component is therefore coded as its own value.
- R2: `out_cat` is the bit length of the 16-bit magnitude of the coded value, from 0 to 16. A zero value gives category 0, and -32768 gives 16.
- R3: For a coded value v > 0, `out_amp` equals v.
- R4: For a coded value v < 0, `out_amp` equals the inverted magnitude masked to the low `out_cat` bits, which is (v - 1) modulo 2^cat.
- R5: Every bit of `out_amp` at position `out_cat` or above is 0.
- R6: When `in_is_dc` is 1, the coded value is `in_coef` minus the predictor of component `in_comp`, taken modulo 2^16. After acceptance that predictor holds `in_coef`.
- R7: Each component has its own predictor, and a DC term of one component leaves the others unchanged.
- R8: An accepted coefficient with `in_is_dc` = 0 is coded as itself and changes no predictor.
- R9: A predictor changes only when a DC term is accepted (`in_valid` and `in_ready` both 1). A DC term held on the input while `in_ready` is 0 has no effect.
- R10: A cycle with `restart` = 1 clears every predictor. A DC term accepted in that same cycle sees a predictor of zero, and its own value is then stored.
- R11: `in_ready` equals (not `out_valid`) or `out_ready`. A coefficient accepted at a clock edge is presented on the outputs with `out_valid` = 1 right after that edge.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_cat` and `out_amp` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Clears all DC predictors (scan start) |
| in_valid | input | 1 | Input coefficient present |
| in_ready | output | 1 | Block can take a coefficient |
| in_coef | input | 16 | Signed coefficient, two's complement |
| in_is_dc | input | 1 | Coefficient is the DC term |
| in_comp | input | 2 | Component index selecting the predictor |
| out_valid | output | 1 | Output fields present |
| out_ready | input | 1 | Consumer takes the output |
| out_cat | output | 5 | Size category 0..16 |
| out_amp | output | 16 | Amplitude bits, zero above the category |

## Verification
The bench builds the block with its defaults: 16-bit coefficients and four components, so the component index is 2 bits wide. With these widths the extreme values are reachable. A magnitude of 32768 gives category 16. A DC difference that wraps past 16 bits, from a predictor of -1 to a coefficient of 32767, can be placed next to the simple cases. All four predictors are exercised together, so crosstalk between components and a restart arriving in the same cycle as a DC term both show up at the outputs.

// File: rtl/coefenc_pkg.sv
package coefenc_pkg;

    // Number of bits needed to hold values 0..n
    function automatic int unsigned len_of(input int unsigned n);
        int unsigned r;
        r = 0;
        while ((n >> r) != 0) r++;
        return (r == 0) ? 1 : r;
    endfunction

    // Index width for a count of items (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dc_pred_bank.sv
module dc_pred_bank #(
    parameter int unsigned VAL_W    = 16,
    parameter int unsigned NUM_COMP = 4,
    parameter int unsigned IDX_W    = coefenc_pkg::idx_width(NUM_COMP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [IDX_W-1:0] sel,
    output logic [VAL_W-1:0] pred,
    input  logic             wr_en,
    input  logic [VAL_W-1:0] wr_val
);

    logic [VAL_W-1:0] slot_q [NUM_COMP];

    for (genvar g = 0; g < NUM_COMP; g++) begin : g_slot
        logic [VAL_W-1:0] slot_d;
        logic             hit;

        always_comb begin
            hit    = wr_en && (sel == IDX_W'(g));
            slot_d = slot_q[g];
            if (clear) slot_d = '0;
            if (hit)   slot_d = wr_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    // A clear seen in the same cycle makes the read return zero
    always_comb begin
        pred = '0;
        for (int k = 0; k < NUM_COMP; k++) begin
            if (sel == IDX_W'(k)) pred = slot_q[k];
        end
        if (clear) pred = '0;
    end

endmodule

// File: rtl/magnitude_sizer.sv
module magnitude_sizer #(
    parameter int unsigned VAL_W = 16,
    parameter int unsigned CAT_W = coefenc_pkg::len_of(VAL_W)
) (
    input  logic [VAL_W-1:0] value,
    output logic             negative,
    output logic [VAL_W-1:0] magnitude,
    output logic [CAT_W-1:0] category
);

    always_comb begin
        negative  = value[VAL_W-1];
        magnitude = negative ? (~value + VAL_W'(1)) : value;
        category  = '0;
        for (int b = 0; b < VAL_W; b++) begin
            if (magnitude[b]) category = CAT_W'(b + 1);
        end
    end

endmodule

// File: rtl/amplitude_former.sv
module amplitude_former #(
    parameter int unsigned VAL_W = 16,
    parameter int unsigned CAT_W = coefenc_pkg::len_of(VAL_W)
) (
    input  logic             negative,
    input  logic [VAL_W-1:0] magnitude,
    input  logic [CAT_W-1:0] category,
    output logic [VAL_W-1:0] amplitude
);

    logic [VAL_W-1:0] keep;
    logic [VAL_W-1:0] raw;

    always_comb begin
        keep = '0;
        for (int b = 0; b < VAL_W; b++) begin
            if (CAT_W'(b) < category) keep[b] = 1'b1;
        end
        raw       = negative ? ~magnitude : magnitude;
        amplitude = raw & keep;
    end

endmodule

// File: rtl/coef_category_encoder.sv
module coef_category_encoder #(
    parameter int unsigned COEF_W   = 16,
    parameter int unsigned NUM_COMP = 4,
    localparam int unsigned COMP_W  = coefenc_pkg::idx_width(NUM_COMP),
    localparam int unsigned CAT_W   = coefenc_pkg::len_of(COEF_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COEF_W-1:0] in_coef,
    input  logic              in_is_dc,
    input  logic [COMP_W-1:0] in_comp,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CAT_W-1:0]  out_cat,
    output logic [COEF_W-1:0] out_amp
);

    typedef struct packed {
        logic              vld;
        logic [CAT_W-1:0]  cat;
        logic [COEF_W-1:0] amp;
    } stage_t;

    stage_t stage_d, stage_q;

    logic              take;
    logic [COEF_W-1:0] pred;
    logic [COEF_W-1:0] coded;
    logic              neg;
    logic [COEF_W-1:0] mag;
    logic [CAT_W-1:0]  cat_w;
    logic [COEF_W-1:0] amp_w;

    assign in_ready = !stage_q.vld || out_ready;
    assign take     = in_valid && in_ready;

    dc_pred_bank #(
        .VAL_W    (COEF_W),
        .NUM_COMP (NUM_COMP),
        .IDX_W    (COMP_W)
    ) u_pred (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .sel    (in_comp),
        .pred   (pred),
        .wr_en  (take && in_is_dc),
        .wr_val (in_coef)
    );

    assign coded = in_is_dc ? (in_coef - pred) : in_coef;

    magnitude_sizer #(
        .VAL_W (COEF_W),
        .CAT_W (CAT_W)
    ) u_size (
        .value     (coded),
        .negative  (neg),
        .magnitude (mag),
        .category  (cat_w)
    );

    amplitude_former #(
        .VAL_W (COEF_W),
        .CAT_W (CAT_W)
    ) u_amp (
        .negative  (neg),
        .magnitude (mag),
        .category  (cat_w),
        .amplitude (amp_w)
    );

    always_comb begin
        stage_d = stage_q;
        if (out_ready) stage_d.vld = 1'b0;
        if (take) begin
            stage_d.vld = 1'b1;
            stage_d.cat = cat_w;
            stage_d.amp = amp_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign out_cat   = stage_q.cat;
    assign out_amp   = stage_q.amp;

endmodule

module coefenc_chk #(
    parameter int unsigned COEF_W = 16,
    parameter int unsigned CAT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_is_dc,
    input logic [COEF_W-1:0] in_coef,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CAT_W-1:0]  out_cat,
    input logic [COEF_W-1:0] out_amp
);

    // R2
    cat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cat <= CAT_W'(COEF_W)));

    // R5
    amp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((32'(out_amp) >> out_cat) == 0));

    // R8
    zero_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_is_dc && in_coef == '0) |=> (out_cat == '0 && out_amp == '0));

    // R11
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_cat) && $stable(out_amp)));

    // R11
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind coef_category_encoder coefenc_chk #(
    .COEF_W (COEF_W),
    .CAT_W  (CAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_is_dc  (in_is_dc),
    .in_coef   (in_coef),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_cat   (out_cat),
    .out_amp   (out_amp)
);

// File: tb/coef_category_encoder_test.sv
module coef_category_encoder_test;

    localparam int COEF_W = 16;
    localparam int NCOMP  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_coef = '0;
    logic        in_is_dc = 1'b0;
    logic [1:0]  in_comp = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [4:0]  out_cat;
    logic [15:0] out_amp;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] mdl_pred [NCOMP];
    logic [20:0] exp_q [$];
    string       req_q [$];
    logic        held = 1'b0;
    logic [4:0]  held_cat;
    logic [15:0] held_amp;

    always #10 clk = ~clk;

    coef_category_encoder #(.COEF_W(COEF_W), .NUM_COMP(NCOMP)) uut (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef),
        .in_is_dc(in_is_dc), .in_comp(in_comp),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_cat(out_cat), .out_amp(out_amp)
    );

    // Expected {category, amplitude} from the requirement text (R2, R3, R4)
    function automatic logic [20:0] encode(input logic [15:0] v);
        int mag, cat, amp;
        mag = v[15] ? (65536 - int'(v)) : int'(v);
        cat = 0;
        for (int b = 0; b < 17; b++) if (((mag >> b) & 1) != 0) cat = b + 1;
        if (v[15]) amp = (~mag) & ((1 << cat) - 1);
        else       amp = mag;
        return {5'(cat), 16'(amp)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic dc, input logic [1:0] comp,
                        input logic [15:0] coef, input logic rs, input logic ordy);
        logic [15:0] cv;
        logic [20:0] e;
        string       tag;
        @(negedge clk);
        in_valid = v; in_is_dc = dc; in_comp = comp; in_coef = coef;
        restart = rs; out_ready = ordy;
        #1;
        // R11: handshake relation and one-cycle presentation
        check("R11 ready", int'(in_ready), int'(!out_valid || out_ready));
        check("R11 valid", int'(out_valid), int'(exp_q.size() != 0));
        // R12: stalled output holds
        if (held) begin
            check("R12 cat", int'(out_cat), int'(held_cat));
            check("R12 amp", int'(out_amp), int'(held_amp));
        end
        if (out_valid && out_ready && exp_q.size() != 0) begin
            e = exp_q.pop_front();
            tag = req_q.pop_front();
            check({tag, " cat"}, int'(out_cat), int'(e[20:16]));
            check({tag, " amp"}, int'(out_amp), int'(e[15:0]));
        end
        if (v && in_ready) begin
            // R6, R10: effective predictor is zero under restart
            cv = dc ? (coef - (rs ? 16'h0 : mdl_pred[comp])) : coef;
            e = encode(cv);
            exp_q.push_back(e);
            if (dc)          tag = rs ? "R10" : "R6";
            else if (cv[15]) tag = "R4";
            else             tag = "R3";
            req_q.push_back(tag);
        end
        if (rs) for (int k = 0; k < NCOMP; k++) mdl_pred[k] = '0;
        // R9: only accepted DC terms update; R8: AC never does
        if (v && in_ready && dc) mdl_pred[comp] = coef;
        held = out_valid && !out_ready;
        held_cat = out_cat;
        held_amp = out_amp;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #3000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NCOMP; k++) mdl_pred[k] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        // R1: first DC per component coded as itself
        step(1, 1, 0, 16'd100, 0, 1);
        step(1, 1, 1, 16'hFFCE, 0, 1);
        // R2/R3/R4 corners on AC terms
        step(1, 0, 0, 16'd0, 0, 1);
        step(1, 0, 0, 16'd1, 0, 1);
        step(1, 0, 0, 16'hFFFF, 0, 1);
        step(1, 0, 0, 16'h7FFF, 0, 1);
        step(1, 0, 0, 16'h8000, 0, 1);
        step(1, 0, 0, 16'hFFF9, 0, 1);
        // R6/R7: differences per component
        step(1, 1, 0, 16'd90, 0, 1);
        step(1, 1, 1, 16'hFFCE, 0, 1);
        // R6: wrap past 16 bits, -1 then 32767
        step(1, 1, 2, 16'hFFFF, 0, 1);
        step(1, 1, 2, 16'h7FFF, 0, 1);
        // R10: restart with DC in same cycle, then difference zero
        step(1, 1, 1, 16'd5, 1, 1);
        step(1, 1, 1, 16'd5, 0, 1);
        step(1, 1, 0, 16'd7, 0, 1);
        // R9/R12: DC offered during a stall
        step(1, 1, 3, 16'd40, 0, 0);
        step(1, 1, 3, 16'd999, 0, 0);
        step(1, 1, 3, 16'd999, 0, 0);
        step(0, 0, 0, 16'd0, 0, 1);
        step(1, 1, 3, 16'd41, 0, 1);
        step(0, 0, 0, 16'd0, 0, 1);
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] c;
            int sh;
            sh = int'($urandom_range(0, 15));
            c = 16'($urandom);
            if ($urandom_range(0, 1) == 1) c = 16'($signed(c) >>> sh);
            step($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
                 2'($urandom_range(0, NCOMP - 1)), c,
                 $urandom_range(0, 60) == 0, $urandom_range(0, 3) != 0);
        end
        repeat (3) step(0, 0, 0, 16'd0, 0, 1);
        finish_run();
    end

endmodule